// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous, symmetric two-port word memory. A left port and a right port each have an active-low select, an active-low write strobe, an active-low output enable, an address, a write-data bus, a read-data bus, an active-low busy input and an active-low interrupt output. Either port can write or read any word at any time. Read data is registered and appears one clock after the read.

The two highest words of the array double as mailboxes. The topmost word is the right side's inbox. A left-port write to it raises the right interrupt. The right port clears that interrupt by selecting the same word with its output enable low. The word just below the top is the left side's inbox and works the same way in the other direction. Mailbox words keep their data like any other word, so the receiver reads the message from the location whose access also clears its interrupt.

A low busy input on the side that causes a flag change holds that flag at its previous value. The storage access itself still happens. Flag changes show on the interrupt outputs one clock after the qualifying access.

Top module: `mbox_dpram`

## Requirements
- R1: A word written through one port (select low, write strobe low) is returned on the other port's read bus one cycle after a read of that address (select low, output enable low, write strobe high).
- R2: A port's read bus is zero in the cycle after any cycle in which that port does not read.
- R3: A left-port write to the top address (all address bits one) with left busy high drives the right interrupt low on the next cycle.
- R4: A right-port access with select and output enable low at the top address, with right busy high, drives the right interrupt high on the next cycle.
- R5: A right-port write to the address one below the top, with right busy high, drives the left interrupt low on the next cycle.
- R6: A left-port access with select and output enable low at the address one below the top, with left busy high, drives the left interrupt high on the next cycle.
- R7: When the busy input of the side causing a set or a clear is low, the affected interrupt keeps its value. The word is still written or read.
- R8: When a set and a clear of the same interrupt fall in the same cycle, the interrupt ends up asserted (low).
- R9: During and after reset both interrupt outputs are high and both read buses are zero.
- R10: Mailbox words store data normally, and a read of a mailbox returns the last word written there.
- R11: Interrupts change only through the accesses in R3 to R6. A port writing to its own inbox, or a port accessing any other address, leaves both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lCeN | input | 1 | Left select, active low |
| lRwN | input | 1 | Left write strobe, low writes, high reads |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | ADDR_W | Left word address |
| lWrData | input | DATA_W | Left write data |
| lBusyN | input | 1 | Left busy, low blocks left-caused flag changes |
| lRdData | output | DATA_W | Left registered read data |
| lIntN | output | 1 | Left interrupt, active low |
| rCeN | input | 1 | Right select, active low |
| rRwN | input | 1 | Right write strobe, low writes, high reads |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | ADDR_W | Right word address |
| rWrData | input | DATA_W | Right write data |
| rBusyN | input | 1 | Right busy, low blocks right-caused flag changes |
| rRdData | output | DATA_W | Right registered read data |
| rIntN | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with a 6-bit address and 9-bit data, so the mailboxes sit at words 63 and 62. With only 64 words, ordinary words and both inboxes can be reached in a short vector table. The 9-bit width keeps the full word size, so the top data bit is covered by the message patterns. With the small array, a write and a clear of one mailbox in the same cycle, busy blocking on either side, and a reset while a flag is set all fit in a few dozen cycles.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Access strobes decoded by control, consumed by the datapath
  typedef struct packed {
    logic lWr;
    logic lRd;
    logic rWr;
    logic rRd;
  } mboxStrobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyN,
  input  logic              rCeN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyN,
  output mboxStrobe_t       stb,
  output logic              lIntN,
  output logic              rIntN
);

  localparam logic [ADDR_W-1:0] INBOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] INBOX_L = INBOX_R - 1'b1;

  logic lSel, rSel, lLook, rLook;
  logic rFlagSet, rFlagClr, lFlagSet, lFlagClr;
  logic rFlag, lFlag;

  assign lSel  = !lCeN;
  assign rSel  = !rCeN;
  // "look" = select and output enable low, write strobe is don't-care
  assign lLook = lSel && !lOeN;
  assign rLook = rSel && !rOeN;

  always_comb begin
    stb     = '0;
    stb.lWr = lSel && !lRwN;
    stb.lRd = lLook && lRwN;
    stb.rWr = rSel && !rRwN;
    stb.rRd = rLook && rRwN;
  end

  // Right inbox: set by the left writer, cleared by the right reader
  assign rFlagSet = stb.lWr && (lAddr == INBOX_R) && lBusyN;
  assign rFlagClr = rLook && (rAddr == INBOX_R) && rBusyN;
  // Left inbox: set by the right writer, cleared by the left reader
  assign lFlagSet = stb.rWr && (rAddr == INBOX_L) && rBusyN;
  assign lFlagClr = lLook && (lAddr == INBOX_L) && lBusyN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rFlag <= 1'b0;
      lFlag <= 1'b0;
    end else begin
      // set takes priority over clear
      if (rFlagSet)      rFlag <= 1'b1;
      else if (rFlagClr) rFlag <= 1'b0;
      if (lFlagSet)      lFlag <= 1'b1;
      else if (lFlagClr) lFlag <= 1'b0;
    end
  end

  assign rIntN = !rFlag;
  assign lIntN = !lFlag;

  assert_right_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!lCeN && !lRwN && lBusyN && (&lAddr)) |=> !rIntN);

  assert_left_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!rCeN && !rRwN && rBusyN && (rAddr == INBOX_L)) |=> !lIntN);

  assert_right_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!rCeN && !rOeN && rBusyN && (&rAddr) &&
     !(!lCeN && !lRwN && lBusyN && (&lAddr))) |=> rIntN);

  assert_right_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(!lCeN && !lRwN && lBusyN && (&lAddr)) &&
    !(!rCeN && !rOeN && rBusyN && (&rAddr)) |=> $stable(rIntN));

  assert_left_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!rCeN && !rRwN && rBusyN && (rAddr == INBOX_L)) &&
    !(!lCeN && !lOeN && lBusyN && (lAddr == INBOX_L)) |=> $stable(lIntN));

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       stb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage: no reset; right port is applied last on a same-word clash
  always_ff @(posedge clk) begin
    if (stb.lWr) mem[lAddr] <= lWrData;
    if (stb.rWr) mem[rAddr] <= rWrData;
  end

  // Registered read buses, zero when the port did not read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lRdData <= '0;
      rRdData <= '0;
    end else begin
      lRdData <= stb.lRd ? mem[lAddr] : '0;
      rRdData <= stb.rRd ? mem[rAddr] : '0;
    end
  end

  assert_left_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.lRd |=> (lRdData == '0));

  assert_right_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rRd |=> (rRdData == '0));

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lCeN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic              lBusyN,
  output logic [DATA_W-1:0] lRdData,
  output logic              lIntN,
  input  logic              rCeN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  input  logic              rBusyN,
  output logic [DATA_W-1:0] rRdData,
  output logic              rIntN
);

  mboxStrobe_t stb;

  mbox_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr), .lBusyN(lBusyN),
    .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr), .rBusyN(rBusyN),
    .stb(stb), .lIntN(lIntN), .rIntN(rIntN)
  );

  mbox_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lAddr(lAddr), .lWrData(lWrData), .rAddr(rAddr), .rWrData(rWrData),
    .lRdData(lRdData), .rRdData(rRdData)
  );

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> (lIntN && rIntN && lRdData == '0 && rRdData == '0));

endmodule

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;

  localparam int AW = 6;
  localparam int DW = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lCeN = 1'b1, lRwN = 1'b1, lOeN = 1'b1, lBusyN = 1'b1;
  logic rCeN = 1'b1, rRwN = 1'b1, rOeN = 1'b1, rBusyN = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic [DW-1:0] lWrData = '0, rWrData = '0;
  logic [DW-1:0] lRdData, rRdData;
  logic lIntN, rIntN;

  int checks = 0;
  int fails = 0;

  always #4 clk = !clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbox_dpram (
    .clk(clk), .rstN(rstN),
    .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr), .lWrData(lWrData),
    .lBusyN(lBusyN), .lRdData(lRdData), .lIntN(lIntN),
    .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr), .rWrData(rWrData),
    .rBusyN(rBusyN), .rRdData(rRdData), .rIntN(rIntN)
  );

  typedef struct packed {
    logic          lCe, lRw, lOe;
    logic [AW-1:0] lA;
    logic [DW-1:0] lD;
    logic          lBz;
    logic          rCe, rRw, rOe;
    logic [AW-1:0] rA;
    logic [DW-1:0] rD;
    logic          rBz;
    logic [DW-1:0] eL, eR;
    logic          eLInt, eRInt;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 14;
  // Inbox words: 63 raises right interrupt, 62 raises left interrupt
  localparam vec_t VEC [NV] = '{
    // R11: left writes plain word 5
    '{1'b0,1'b0,1'b1,6'd5,9'h1A5,1'b1, 1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 9'h000,9'h000,1'b1,1'b1, 8'd11},
    // R1: right reads word 5
    '{1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 1'b0,1'b1,1'b0,6'd5,9'h000,1'b1, 9'h000,9'h1A5,1'b1,1'b1, 8'd1},
    // R3: left writes right inbox
    '{1'b0,1'b0,1'b1,6'd63,9'h0C3,1'b1, 1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 9'h000,9'h000,1'b1,1'b0, 8'd3},
    // R4: right reads right inbox, message returned, interrupt clears
    '{1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 1'b0,1'b1,1'b0,6'd63,9'h000,1'b1, 9'h000,9'h0C3,1'b1,1'b1, 8'd4},
    // R5: right writes left inbox
    '{1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 1'b0,1'b0,1'b1,6'd62,9'h155,1'b1, 9'h000,9'h000,1'b0,1'b1, 8'd5},
    // R6: left reads left inbox
    '{1'b0,1'b1,1'b0,6'd62,9'h000,1'b1, 1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 9'h155,9'h000,1'b1,1'b1, 8'd6},
    // R7: left writes right inbox while left busy: no set
    '{1'b0,1'b0,1'b1,6'd63,9'h011,1'b0, 1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 9'h000,9'h000,1'b1,1'b1, 8'd7},
    // R3: left writes right inbox, busy released
    '{1'b0,1'b0,1'b1,6'd63,9'h0F0,1'b1, 1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 9'h000,9'h000,1'b1,1'b0, 8'd3},
    // R7: right reads inbox while right busy: data returned, no clear
    '{1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 1'b0,1'b1,1'b0,6'd63,9'h000,1'b0, 9'h000,9'h0F0,1'b1,1'b0, 8'd7},
    // R8: set and clear of the right interrupt together: stays asserted
    '{1'b0,1'b0,1'b1,6'd63,9'h0F0,1'b1, 1'b0,1'b1,1'b0,6'd63,9'h000,1'b1, 9'h000,9'h0F0,1'b1,1'b0, 8'd8},
    // R4: right reads inbox alone: clears
    '{1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 1'b0,1'b1,1'b0,6'd63,9'h000,1'b1, 9'h000,9'h0F0,1'b1,1'b1, 8'd4},
    // R11: right writes its own inbox: no flag change
    '{1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 1'b0,1'b0,1'b1,6'd63,9'h1FF,1'b1, 9'h000,9'h000,1'b1,1'b1, 8'd11},
    // R10: left reads word 63, sees right's data; no flag change
    '{1'b0,1'b1,1'b0,6'd63,9'h000,1'b1, 1'b1,1'b1,1'b1,6'd0,9'h000,1'b1, 9'h1FF,9'h000,1'b1,1'b1, 8'd10},
    // R2: left selected with output enable high, right idle: buses zero
    '{1'b0,1'b1,1'b1,6'd63,9'h000,1'b1, 1'b1,1'b1,1'b1,6'd63,9'h000,1'b1, 9'h000,9'h000,1'b1,1'b1, 8'd2}
  };

  task automatic check(string req, logic [DW-1:0] aL, logic [DW-1:0] aR, logic aLi, logic aRi,
                       logic [DW-1:0] eL, logic [DW-1:0] eR, logic eLi, logic eRi);
    checks++;
    if (aL !== eL || aR !== eR || aLi !== eLi || aRi !== eRi) begin
      fails++;
      $display("FAIL %s: got lRd=%h rRd=%h lInt=%b rInt=%b, expected lRd=%h rRd=%h lInt=%b rInt=%b",
               req, aL, aR, aLi, aRi, eL, eR, eLi, eRi);
    end
  endtask

  task automatic idle();
    lCeN = 1'b1; lRwN = 1'b1; lOeN = 1'b1; lBusyN = 1'b1;
    rCeN = 1'b1; rRwN = 1'b1; rOeN = 1'b1; rBusyN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs quiet while in reset
    check("R9", lRdData, rRdData, lIntN, rIntN, '0, '0, 1'b1, 1'b1);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      lCeN = VEC[i].lCe; lRwN = VEC[i].lRw; lOeN = VEC[i].lOe;
      lAddr = VEC[i].lA; lWrData = VEC[i].lD; lBusyN = VEC[i].lBz;
      rCeN = VEC[i].rCe; rRwN = VEC[i].rRw; rOeN = VEC[i].rOe;
      rAddr = VEC[i].rA; rWrData = VEC[i].rD; rBusyN = VEC[i].rBz;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VEC[i].req, i), lRdData, rRdData, lIntN, rIntN,
            VEC[i].eL, VEC[i].eR, VEC[i].eLInt, VEC[i].eRInt);
    end

    // R5 and R7: right writes left inbox while right busy: no set
    idle();
    rCeN = 1'b0; rRwN = 1'b0; rAddr = 6'd62; rWrData = 9'h0AA; rBusyN = 1'b0;
    @(negedge clk);
    check("R7 left-set blocked", lRdData, rRdData, lIntN, rIntN, '0, '0, 1'b1, 1'b1);

    // R5 then R8 on the left inbox: set and clear together
    idle();
    rCeN = 1'b0; rRwN = 1'b0; rAddr = 6'd62; rWrData = 9'h0AB;
    lCeN = 1'b0; lOeN = 1'b0; lAddr = 6'd62;
    @(negedge clk);
    check("R8 left set wins", lRdData, rRdData, lIntN, rIntN, 9'h0AA, '0, 1'b0, 1'b1);

    // R7: left clear blocked by left busy, word still read
    idle();
    lCeN = 1'b0; lOeN = 1'b0; lAddr = 6'd62; lBusyN = 1'b0;
    @(negedge clk);
    check("R7 left-clear blocked", lRdData, rRdData, lIntN, rIntN, 9'h0AB, '0, 1'b0, 1'b1);

    // R1: right write, left read of a plain word
    idle();
    rCeN = 1'b0; rRwN = 1'b0; rAddr = 6'd17; rWrData = 9'h133;
    @(negedge clk);
    idle();
    lCeN = 1'b0; lOeN = 1'b0; lAddr = 6'd17;
    @(negedge clk);
    check("R1 right-to-left", lRdData, rRdData, lIntN, rIntN, 9'h133, '0, 1'b0, 1'b1);

    // R9: set right interrupt too, then reset clears both
    idle();
    lCeN = 1'b0; lRwN = 1'b0; lAddr = 6'd63; lWrData = 9'h001;
    @(negedge clk);
    idle();
    check("R3 before reset", lRdData, rRdData, lIntN, rIntN, '0, '0, 1'b0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    check("R9 mid-run reset", lRdData, rRdData, lIntN, rIntN, '0, '0, 1'b1, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after reset", lRdData, rRdData, lIntN, rIntN, '0, '0, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule